// File: doc/BRIEF.md
# Bus Error Capture and Logging Unit

This block sits beside a bus protocol engine and keeps a record of the errors seen on the bus. The engine reports each error as a single-cycle event. The event carries a kind code, a direction flag and the address of the failing transaction. The unit keeps a 4-bit cause code and the address of the first error only. It raises a sticky flag when further errors arrive while that first error is still pending. It also raises a separate sticky flag whenever an error belongs to a transfer that this device started as bus master. Software reads these values and discards them with a one-cycle clear pulse.

The unit also turns stalled and endlessly retried master transfers into abort errors, using two local counters. The data-phase timer runs from the start of a data phase until the target responds with either a ready or a stop. If the programmed number of clocks passes first, the timer fires. The retry counter counts retry terminations on the current transfer. It fires once the count passes the programmed limit. Either counter firing logs an abort error and sends a one-cycle abort request back to the engine.

The cause code is `{rd, tgt, fatal, par}`, with the most significant bit first. Logging is handled by a three-state machine. `LOG_CLEAR` means nothing is pending. `LOG_FIRST` means one error is held. `LOG_MULTI` means a further error arrived while one was pending. The transitions are:
- `record` moves from `LOG_CLEAR` to `LOG_FIRST`, or to `LOG_MULTI` when several errors arrive at once.
- `pile_up` moves from `LOG_FIRST` to `LOG_MULTI`.
- `wipe` moves from any state back to `LOG_CLEAR`.
- `wipe_and_record` clears the old state and logs a new error as a first error in the same cycle.

The timer uses two states: `TMR_IDLE` and `TMR_WAIT`. Its transitions are `arm`, `rearm`, `respond` and `expire`. The retry counter also uses two states: `RTY_IDLE` and `RTY_COUNT`. Its transitions are `bump`, `complete` and `give_up`.

Top module: `buserr_logger`

## Requirements
- R1: After reset, err_code is 0000, err_multi and err_master are 0, err_addr is 0, and perr_out and abort_req are 0.
- R2: An event with ev_kind encodes as follows, in bit order {rd,tgt,fatal,par}:
  - 0 is a no-response master abort. It logs 1010 when ev_read=1 and 0010 when ev_read=0.
  - 1 is a target abort. It logs 0100.
  - 2 is a parity error on write data received while this device is a target. It logs 0101.
  - 3 is a parity error on read data. It logs 1001.
  - 4 is a parity error reported by a target on this device's write data. It logs 0001.
  - Kinds 2, 3 and 4 ignore ev_read.
  - Kinds 5 to 7 are not errors and log nothing.
- R3: The first error's code and address appear after the clock edge that samples the error. They stay unchanged until a clear, whatever later errors arrive.
- R4: A further error of any kind, arriving while a code is held, sets err_multi after that edge. err_multi stays set until a clear.
- R5: A clear pulse with no new error resets err_code, err_multi and err_master. A clear together with a new error logs that error as a first error, with err_multi at 0.
- R6: err_master is set by every error except kind 2, including timeout and retry aborts. It is set even if the error is not the first one. It stays set until a clear.
- R7: perr_out is high for exactly the one cycle after the edge that samples a kind 2 event.
- R8: Suppose dp_start is sampled and neither dp_ack nor a new dp_start is sampled within to_limit clocks. Then the error is logged at the to_limit-th edge after that start. It logs 1010 if txn_read=1 and 0010 if txn_read=0, and the captured address is txn_addr. A dp_ack inside the window cancels the timeout.
- R9: When to_limit is 0, the timeout never fires. A dp_start during a running window restarts the count.
- R10: With mr_limit=M>0, the (M+1)-th retry_seen pulse since the last txn_ok logs 0010 at the edge that samples it, with address txn_addr. The counter then restarts. txn_ok resets the count. mr_limit=0 disables the check.
- R11: abort_req is high for exactly the one cycle after the edge that logs a timeout or retry abort.
- R12: When several error sources fire in the same cycle, one code is logged and err_multi is also set. The event input has the highest priority, then the timeout, then the retry abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | One-cycle clear of the logged error state |
| ev_valid | input | 1 | Error event pulse from the protocol engine |
| ev_kind | input | 3 | Error kind, encoded as in R2 |
| ev_read | input | 1 | Event belongs to a read transfer |
| ev_addr | input | AW | Address of the failing transfer |
| txn_read | input | 1 | Current master transfer is a read |
| txn_addr | input | AW | Address of the current master transfer |
| dp_start | input | 1 | Data phase begins (address was claimed) |
| dp_ack | input | 1 | Target gave ready or stop in the data phase |
| retry_seen | input | 1 | Target ended the transfer with a retry |
| txn_ok | input | 1 | Current master transfer completed normally |
| to_limit | input | TW | Data-phase timeout in clocks, 0 = off |
| mr_limit | input | RW | Retries allowed, 0 = off |
| err_code | output | 4 | Held first-error code {rd,tgt,fatal,par} |
| err_multi | output | 1 | More than one error since the last clear |
| err_master | output | 1 | A master-mode error occurred |
| err_addr | output | AW | Address of the first error |
| perr_out | output | 1 | Parity-error pulse for target write data |
| abort_req | output | 1 | Abort request after timeout or retry limit |

## Verification
A log machine stuck in the wrong state has two visible symptoms. Either err_multi is wrong after the second error, or err_code and err_addr change when a later error arrives. Both appear one edge after that second error. A wrong kind decode gives a wrong err_code or err_master right after the edge that samples the event. An off-by-one in either counter moves the logged abort one edge earlier or later. The timeout and retry checks sample the edge before the expected one and the expected edge itself, so such a shift shows up within one clock.

// File: rtl/buserr_pkg.sv
package buserr_pkg;

    typedef enum logic [2:0] {
        EVK_NORESP   = 3'd0,
        EVK_TGTABORT = 3'd1,
        EVK_TWPAR    = 3'd2,
        EVK_RDPAR    = 3'd3,
        EVK_PEERPAR  = 3'd4
    } ev_kind_e;

    typedef enum logic [1:0] {
        LOG_CLEAR,
        LOG_FIRST,
        LOG_MULTI
    } log_state_e;

    typedef enum logic {
        TMR_IDLE,
        TMR_WAIT
    } tmr_state_e;

    typedef enum logic {
        RTY_IDLE,
        RTY_COUNT
    } rty_state_e;

    localparam logic [3:0] CODE_NONE = 4'b0000;
    localparam logic [3:0] CODE_ABRT_RD = 4'b1010;
    localparam logic [3:0] CODE_ABRT_WR = 4'b0010;

    // Cause code {rd, tgt, fatal, par} for an event kind
    function automatic logic [3:0] kind_code(input logic [2:0] kind, input logic rd);
        logic [3:0] c;
        unique case (kind)
            EVK_NORESP:   c = rd ? CODE_ABRT_RD : CODE_ABRT_WR;
            EVK_TGTABORT: c = 4'b0100;
            EVK_TWPAR:    c = 4'b0101;
            EVK_RDPAR:    c = 4'b1001;
            EVK_PEERPAR:  c = 4'b0001;
            default:      c = CODE_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/buserr_timer.sv
module buserr_timer
    import buserr_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ack,
    input  logic [TW-1:0] limit,
    output logic          fire
);

    tmr_state_e    st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        unique case (st_q)
            TMR_IDLE: begin
                if (start && limit != '0) begin   // arm
                    st_d  = TMR_WAIT;
                    cnt_d = '0;
                end
            end
            TMR_WAIT: begin
                if (start) begin                   // rearm
                    st_d  = (limit != '0) ? TMR_WAIT : TMR_IDLE;
                    cnt_d = '0;
                end else if (ack || limit == '0) begin   // respond
                    st_d  = TMR_IDLE;
                    cnt_d = '0;
                end else if (cnt_q >= limit - 1'b1) begin  // expire
                    fire  = 1'b1;
                    st_d  = TMR_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = TMR_IDLE;
                cnt_d = '0;
            end
        endcase
    end

endmodule

// File: rtl/buserr_retry.sv
module buserr_retry
    import buserr_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retry,
    input  logic          ok,
    input  logic [RW-1:0] limit,
    output logic          fire
);

    rty_state_e    st_q, st_d;
    logic [RW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RTY_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        unique case (st_q)
            RTY_IDLE, RTY_COUNT: begin
                if (ok) begin                         // complete
                    st_d  = RTY_IDLE;
                    cnt_d = '0;
                end else if (retry) begin
                    if (limit == '0) begin
                        st_d  = RTY_IDLE;
                        cnt_d = '0;
                    end else if (cnt_q >= limit) begin // give_up
                        fire  = 1'b1;
                        st_d  = RTY_IDLE;
                        cnt_d = '0;
                    end else begin                     // bump
                        st_d  = RTY_COUNT;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = RTY_IDLE;
                cnt_d = '0;
            end
        endcase
    end

endmodule

// File: rtl/buserr_log.sv
module buserr_log
    import buserr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ev_hit,
    input  logic [3:0]    ev_code,
    input  logic          ev_master,
    input  logic [AW-1:0] ev_addr,
    input  logic          tmo_fire,
    input  logic          rty_fire,
    input  logic          txn_read,
    input  logic [AW-1:0] txn_addr,
    output logic [3:0]    err_code,
    output logic          err_multi,
    output logic          err_master,
    output logic [AW-1:0] err_addr
);

    localparam int NSRC = 3;

    log_state_e    st_q, st_d;
    logic [3:0]    code_q, code_d, new_code;
    logic [AW-1:0] addr_q, addr_d, new_addr;
    logic          bm_q, bm_d, new_master;
    logic [NSRC-1:0] srcs;
    logic          any_new, many_new;

    assign srcs     = {rty_fire, tmo_fire, ev_hit};
    assign any_new  = |srcs;
    assign many_new = ($countones(srcs) > 1);

    // priority: event, then timeout, then retry
    always_comb begin
        new_code = CODE_NONE;
        new_addr = '0;
        if (ev_hit) begin
            new_code = ev_code;
            new_addr = ev_addr;
        end else if (tmo_fire) begin
            new_code = txn_read ? CODE_ABRT_RD : CODE_ABRT_WR;
            new_addr = txn_addr;
        end else if (rty_fire) begin
            new_code = CODE_ABRT_WR;
            new_addr = txn_addr;
        end
    end

    assign new_master = (ev_hit && ev_master) || tmo_fire || rty_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LOG_CLEAR;
            code_q <= CODE_NONE;
            addr_q <= '0;
            bm_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
            addr_q <= addr_d;
            bm_q   <= bm_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        addr_d = addr_q;
        bm_d   = bm_q | new_master;
        if (clr || st_q == LOG_CLEAR) begin
            if (any_new) begin                 // record / wipe_and_record
                st_d   = many_new ? LOG_MULTI : LOG_FIRST;
                code_d = new_code;
                addr_d = new_addr;
                bm_d   = new_master;
            end else begin                     // wipe
                st_d   = LOG_CLEAR;
                code_d = CODE_NONE;
                addr_d = '0;
                bm_d   = 1'b0;
            end
        end else begin
            unique case (st_q)
                LOG_FIRST: if (any_new) st_d = LOG_MULTI;   // pile_up
                LOG_MULTI: st_d = LOG_MULTI;
                default:   st_d = LOG_CLEAR;
            endcase
        end
    end

    always_comb begin
        err_code   = code_q;
        err_addr   = addr_q;
        err_master = bm_q;
        err_multi  = (st_q == LOG_MULTI);
    end

endmodule

// File: rtl/buserr_logger.sv
module buserr_logger
    import buserr_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ev_valid,
    input  logic [2:0]    ev_kind,
    input  logic          ev_read,
    input  logic [AW-1:0] ev_addr,
    input  logic          txn_read,
    input  logic [AW-1:0] txn_addr,
    input  logic          dp_start,
    input  logic          dp_ack,
    input  logic          retry_seen,
    input  logic          txn_ok,
    input  logic [TW-1:0] to_limit,
    input  logic [RW-1:0] mr_limit,
    output logic [3:0]    err_code,
    output logic          err_multi,
    output logic          err_master,
    output logic [AW-1:0] err_addr,
    output logic          perr_out,
    output logic          abort_req
);

    logic       tmo_fire, rty_fire;
    logic [3:0] ev_code;
    logic       ev_hit, ev_master;

    assign ev_code   = kind_code(ev_kind, ev_read);
    assign ev_hit    = ev_valid && (ev_code != CODE_NONE);
    assign ev_master = (ev_kind != EVK_TWPAR);

    buserr_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dp_start),
        .ack   (dp_ack),
        .limit (to_limit),
        .fire  (tmo_fire)
    );

    buserr_retry #(.RW(RW)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .retry (retry_seen),
        .ok    (txn_ok),
        .limit (mr_limit),
        .fire  (rty_fire)
    );

    buserr_log #(.AW(AW)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .ev_hit     (ev_hit),
        .ev_code    (ev_code),
        .ev_master  (ev_master),
        .ev_addr    (ev_addr),
        .tmo_fire   (tmo_fire),
        .rty_fire   (rty_fire),
        .txn_read   (txn_read),
        .txn_addr   (txn_addr),
        .err_code   (err_code),
        .err_multi  (err_multi),
        .err_master (err_master),
        .err_addr   (err_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perr_out  <= 1'b0;
            abort_req <= 1'b0;
        end else begin
            perr_out  <= ev_valid && (ev_kind == EVK_TWPAR);
            abort_req <= tmo_fire || rty_fire;
        end
    end

endmodule

// File: rtl/buserr_logger_chk.sv
module buserr_logger_chk #(
    parameter int AW = 32,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          ev_valid,
    input logic [2:0]    ev_kind,
    input logic          ev_hit,
    input logic          ev_master,
    input logic          tmo_fire,
    input logic          rty_fire,
    input logic [TW-1:0] to_limit,
    input logic [3:0]    err_code,
    input logic          err_multi,
    input logic          err_master,
    input logic [AW-1:0] err_addr,
    input logic          perr_out,
    input logic          abort_req
);

    // R3
    first_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 4'b0000 && !clr) |=> ($stable(err_code) && $stable(err_addr)));

    // R4
    multi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 4'b0000 && !clr && (ev_hit || tmo_fire || rty_fire)) |=> err_multi);

    // R4
    multi_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi |-> (err_code != 4'b0000));

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_hit && !tmo_fire && !rty_fire) |=> (err_code == 4'b0000 && !err_multi && !err_master));

    // R6
    master_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_hit && ev_master) || tmo_fire || rty_fire) |=> err_master);

    // R7
    perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 3'd2) |=> perr_out);

    // R9
    timeout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_limit == '0) |-> !tmo_fire);

    // R11
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_fire || rty_fire) |=> abort_req);

endmodule

bind buserr_logger buserr_logger_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_hit     (ev_hit),
    .ev_master  (ev_master),
    .tmo_fire   (tmo_fire),
    .rty_fire   (rty_fire),
    .to_limit   (to_limit),
    .err_code   (err_code),
    .err_multi  (err_multi),
    .err_master (err_master),
    .err_addr   (err_addr),
    .perr_out   (perr_out),
    .abort_req  (abort_req)
);

// File: tb/test_buserr_logger.sv
`timescale 1ns/1ps
module test_buserr_logger;

    localparam int AW = 32;
    localparam int TW = 16;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          ev_valid = 1'b0;
    logic [2:0]    ev_kind = '0;
    logic          ev_read = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic          txn_read = 1'b0;
    logic [AW-1:0] txn_addr = '0;
    logic          dp_start = 1'b0;
    logic          dp_ack = 1'b0;
    logic          retry_seen = 1'b0;
    logic          txn_ok = 1'b0;
    logic [TW-1:0] to_limit = '0;
    logic [RW-1:0] mr_limit = '0;
    logic [3:0]    err_code;
    logic          err_multi, err_master, perr_out, abort_req;
    logic [AW-1:0] err_addr;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    buserr_logger #(.AW(AW), .TW(TW), .RW(RW)) i_buserr_logger (.*);

    // {kind[2:0], read, code[3:0], master}
    localparam int NV = 10;
    localparam logic [8:0] VEC [NV] = '{
        {3'd0, 1'b1, 4'b1010, 1'b1},
        {3'd0, 1'b0, 4'b0010, 1'b1},
        {3'd1, 1'b1, 4'b0100, 1'b1},
        {3'd1, 1'b0, 4'b0100, 1'b1},
        {3'd2, 1'b0, 4'b0101, 1'b0},
        {3'd2, 1'b1, 4'b0101, 1'b0},
        {3'd3, 1'b1, 4'b1001, 1'b1},
        {3'd3, 1'b0, 4'b1001, 1'b1},
        {3'd4, 1'b0, 4'b0001, 1'b1},
        {3'd4, 1'b1, 4'b0001, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    task automatic send_ev(input logic [2:0] k, input logic rd, input logic [AW-1:0] a);
        ev_valid = 1'b1; ev_kind = k; ev_read = rd; ev_addr = a;
        tick();
        ev_valid = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 code", err_code, 0);
        chk("R1 multi", err_multi, 0);
        chk("R1 master", err_master, 0);
        chk("R1 addr", err_addr, 0);
        chk("R1 perr", perr_out, 0);
        chk("R1 abort", abort_req, 0);

        // R2 table walk
        for (int i = 0; i < NV; i++) begin
            do_clear();
            send_ev(VEC[i][8:6], VEC[i][5], 32'h1000 + i);
            chk("R2 code", err_code, VEC[i][4:1]);
            chk("R6 master", err_master, VEC[i][0]);
            chk("R3 addr", err_addr, 32'h1000 + i);
            chk("R4 multi", err_multi, 0);
        end

        // R2 invalid kind logs nothing
        do_clear();
        send_ev(3'd6, 1'b1, 32'hBAD);
        chk("R2 invalid kind", err_code, 0);

        // R3 / R4 first held, multi set
        do_clear();
        send_ev(3'd3, 1'b1, 32'hAAAA);
        send_ev(3'd1, 1'b0, 32'hBBBB);
        chk("R3 held code", err_code, 4'b1001);
        chk("R3 held addr", err_addr, 32'hAAAA);
        chk("R4 multi", err_multi, 1);

        // R5 clear with new error at same cycle
        clr = 1'b1;
        send_ev(3'd4, 1'b0, 32'hCCCC);
        clr = 1'b0;
        chk("R5 new code", err_code, 4'b0001);
        chk("R5 new addr", err_addr, 32'hCCCC);
        chk("R5 multi clr", err_multi, 0);
        do_clear();
        chk("R5 wiped code", err_code, 0);
        chk("R5 wiped master", err_master, 0);

        // R6 / R7 target parity then master error
        send_ev(3'd2, 1'b0, 32'hD0);
        chk("R7 perr high", perr_out, 1);
        chk("R6 master low", err_master, 0);
        tick();
        chk("R7 perr low", perr_out, 0);
        send_ev(3'd0, 1'b0, 32'hD1);
        chk("R6 master late", err_master, 1);
        chk("R3 code kept", err_code, 4'b0101);

        // R8 / R11 timeout on read
        do_clear();
        to_limit = 16'd4; txn_read = 1'b1; txn_addr = 32'h5000;
        dp_start = 1'b1; tick(); dp_start = 1'b0;
        repeat (3) tick();
        chk("R8 not yet", err_code, 0);
        tick();
        chk("R8 rd code", err_code, 4'b1010);
        chk("R8 addr", err_addr, 32'h5000);
        chk("R11 abort", abort_req, 1);
        tick();
        chk("R11 abort drop", abort_req, 0);

        // R8 write timeout with to_limit 1
        do_clear();
        to_limit = 16'd1; txn_read = 1'b0;
        dp_start = 1'b1; tick(); dp_start = 1'b0;
        tick();
        chk("R8 wr code", err_code, 4'b0010);

        // R8 ack inside window
        do_clear();
        to_limit = 16'd4;
        dp_start = 1'b1; tick(); dp_start = 1'b0;
        repeat (2) tick();
        dp_ack = 1'b1; tick(); dp_ack = 1'b0;
        repeat (6) tick();
        chk("R8 ack cancels", err_code, 0);

        // R9 restart
        dp_start = 1'b1; tick(); dp_start = 1'b0;
        repeat (2) tick();
        dp_start = 1'b1; tick(); dp_start = 1'b0;
        repeat (3) tick();
        chk("R9 restart no fire", err_code, 0);
        tick();
        chk("R9 restart fires", err_code, 4'b0010);

        // R9 disabled
        do_clear();
        to_limit = '0;
        dp_start = 1'b1; tick(); dp_start = 1'b0;
        repeat (20) tick();
        chk("R9 off", err_code, 0);

        // R10 retry limit
        mr_limit = 8'd2; txn_addr = 32'h6000;
        repeat (2) begin retry_seen = 1'b1; tick(); end
        retry_seen = 1'b0;
        chk("R10 under", err_code, 0);
        retry_seen = 1'b1; tick(); retry_seen = 1'b0;
        chk("R10 code", err_code, 4'b0010);
        chk("R10 addr", err_addr, 32'h6000);
        chk("R11 rty abort", abort_req, 1);

        // R10 txn_ok resets
        do_clear();
        repeat (2) begin retry_seen = 1'b1; tick(); end
        retry_seen = 1'b0;
        txn_ok = 1'b1; tick(); txn_ok = 1'b0;
        repeat (2) begin retry_seen = 1'b1; tick(); end
        retry_seen = 1'b0;
        chk("R10 ok reset", err_code, 0);
        retry_seen = 1'b1; tick(); retry_seen = 1'b0;
        chk("R10 after ok", err_code, 4'b0010);

        // R10 disabled
        do_clear();
        mr_limit = '0;
        repeat (10) begin retry_seen = 1'b1; tick(); end
        retry_seen = 1'b0;
        chk("R10 off", err_code, 0);

        // R12 event and retry abort same cycle
        mr_limit = 8'd1; txn_addr = 32'h7000;
        retry_seen = 1'b1; tick();
        ev_valid = 1'b1; ev_kind = 3'd1; ev_addr = 32'h7100;
        tick();
        ev_valid = 1'b0; retry_seen = 1'b0;
        chk("R12 priority code", err_code, 4'b0100);
        chk("R12 priority addr", err_addr, 32'h7100);
        chk("R12 multi", err_multi, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule